// File: doc/BRIEF.md
# Single-Master Peripheral Bus Hub

This block joins one processor core to a row of slave peripherals. The core presents a single 32-bit address, a 32-bit write word and separate write and read strobes. It receives one shared read-data word and one shared pair of status flags. The top four address bits name a slave slot. The remaining 28 bits go to every slave unchanged, as a port or command number. Only the slave in the named slot gets a write or read strobe, and only that slave's status and data reach the core.

Each slave reports two flags. The first says it can take a write word now. The second says a word is waiting to be read on the port that the low address bits name. The hub gates the strobes with these flags. It raises a combinational stall output whenever the core's strobe meets a flag that is low. A scheduler can use this to park the thread that issued the blocking access.

Read data is registered. A read accepted in one cycle shows its word, with a valid pulse, in the next cycle. Slots at or above the configured slave count are empty.

Top module: `devbus_hub`

## Requirements
- R1: After reset, `m_rdata` is zero and `m_rvalid` is low.
- R2: The slot number is `m_addr[31:28]`. At most one bit of `s_wr` and at most one bit of `s_rd` is high, and it is always the bit whose index equals the slot number.
- R3: `s_port` always equals `m_addr[27:0]`, and `s_wdata` always equals `m_wdata`, whatever the slot.
- R4: In the same cycle, `m_ready` and `m_avail` equal `s_ready` and `s_avail` at the index of the addressed slot.
- R5: A slot number of `NUM_SLV` or more is empty. For such a slot, `m_ready` and `m_avail` are 0 and no slave strobe is raised. A read to it gives `m_rdata` = 0 with `m_rvalid` low in the next cycle.
- R6: `s_wr[k]` is high only in a cycle where `m_wr` is high, slot k is addressed and `s_ready[k]` is high.
- R7: `s_rd[k]` is high only in a cycle where `m_rd` is high, slot k is addressed and `s_avail[k]` is high.
- R8: `m_stall` is high in the same cycle exactly when (`m_wr` and not `m_ready`) or (`m_rd` and not `m_avail`).
- R9: After a cycle with an accepted read, `m_rdata` holds the word that the addressed slave drove in that cycle, and `m_rvalid` is high for that one cycle.
- R10: After a cycle with `m_rd` high but no accepted read, `m_rdata` is 0 and `m_rvalid` is low. After a cycle with `m_rd` low, `m_rdata` keeps its value and `m_rvalid` is low.
- R11: A write and a read in the same cycle are each gated by their own flag. A read accepted together with a write to the same slave returns the word from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_addr | input | 32 | Core address: slot field and port number |
| m_wdata | input | 32 | Core write word |
| m_wr | input | 1 | Core write strobe |
| m_rd | input | 1 | Core read strobe |
| m_rdata | output | 32 | Registered read word |
| m_rvalid | output | 1 | Registered pulse: m_rdata holds an accepted read |
| m_ready | output | 1 | Addressed slave can take a write |
| m_avail | output | 1 | Addressed slave has read data waiting |
| m_stall | output | 1 | Current strobe is blocked |
| s_port | output | 28 | Port or command number, sent to all slaves |
| s_wdata | output | 32 | Write word, sent to all slaves |
| s_wr | output | NUM_SLV | Gated write strobe, one per slave |
| s_rd | output | NUM_SLV | Gated read strobe, one per slave |
| s_rdata | input | NUM_SLV*32 | Read words, slave k at bits [32k+31:32k] |
| s_ready | input | NUM_SLV | Per-slave ready-to-accept flag |
| s_avail | input | NUM_SLV | Per-slave data-available flag |

## Verification
Write gating and read gating can act in the same cycle. The two strobes can also target one slave, so an accepted read meets a write to the very register it returns. The stimulus raises both strobes together with every mix of the two flags. It aims at the last populated slot, at empty slots, and at the same slave on back-to-back cycles. A behavioural model in the bench keeps its own copy of every stub register. It predicts the gated strobes, the stall and the next-cycle read word from the pre-write contents, and every cycle is compared against it.

// File: rtl/devbus_pkg.sv
package devbus_pkg;
    localparam int unsigned ADDR_W_DEF = 32;
    localparam int unsigned DATA_W_DEF = 32;
    localparam int unsigned SEL_W_DEF  = 4;

    typedef enum logic [1:0] {
        RD_NONE    = 2'd0,
        RD_TAKEN   = 2'd1,
        RD_BLOCKED = 2'd2
    } rd_res_e;
endpackage

// File: rtl/devbus_decode.sv
module devbus_decode #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned SEL_W   = 4,
    parameter int unsigned NUM_SLV = 12,
    localparam int unsigned PORT_W = ADDR_W - SEL_W
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_SLV-1:0] sel_oh,
    output logic [PORT_W-1:0]  port
);
    logic [SEL_W-1:0] slot_field;

    assign slot_field = addr[ADDR_W-1 -: SEL_W];
    assign port       = addr[PORT_W-1:0];

    for (genvar g = 0; g < NUM_SLV; g++) begin : g_slot
        localparam logic [SEL_W-1:0] SLOT_ID = SEL_W'(g);
        assign sel_oh[g] = (slot_field == SLOT_ID);
    end
endmodule

// File: rtl/devbus_status.sv
module devbus_status
    import devbus_pkg::*;
#(
    parameter int unsigned NUM_SLV = 12
) (
    input  logic [NUM_SLV-1:0] sel_oh,
    input  logic [NUM_SLV-1:0] s_ready,
    input  logic [NUM_SLV-1:0] s_avail,
    input  logic               m_wr,
    input  logic               m_rd,
    output logic               ready,
    output logic               avail,
    output logic               stall,
    output logic [NUM_SLV-1:0] wr_oh,
    output logic [NUM_SLV-1:0] rd_oh,
    output rd_res_e            rd_res
);
    always_comb begin
        ready = |(sel_oh & s_ready);
        avail = |(sel_oh & s_avail);
        wr_oh = (m_wr && ready) ? sel_oh : '0;
        rd_oh = (m_rd && avail) ? sel_oh : '0;
        stall = (m_wr && !ready) || (m_rd && !avail);
        if (!m_rd)
            rd_res = RD_NONE;
        else if (avail)
            rd_res = RD_TAKEN;
        else
            rd_res = RD_BLOCKED;
    end
endmodule

// File: rtl/devbus_retmux.sv
module devbus_retmux
    import devbus_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_SLV = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SLV-1:0]        sel_oh,
    input  logic [NUM_SLV*DATA_W-1:0] s_rdata,
    input  rd_res_e                   rd_res,
    output logic [DATA_W-1:0]         m_rdata,
    output logic                      m_rvalid
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } ret_st_t;

    ret_st_t           st_d, st_q;
    logic [DATA_W-1:0] pick;

    always_comb begin
        pick = '0;
        for (int i = 0; i < NUM_SLV; i++) begin
            if (sel_oh[i])
                pick = pick | s_rdata[i*DATA_W +: DATA_W];
        end
        st_d = st_q;
        unique case (rd_res)
            RD_TAKEN: begin
                st_d.rdata  = pick;
                st_d.rvalid = 1'b1;
            end
            RD_BLOCKED: begin
                st_d.rdata  = '0;
                st_d.rvalid = 1'b0;
            end
            default: st_d.rvalid = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign m_rdata  = st_q.rdata;
    assign m_rvalid = st_q.rvalid;

    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_res == RD_NONE) |=> ($stable(m_rdata) && !m_rvalid));
    a_r10_blocked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_res == RD_BLOCKED) |=> (m_rdata == '0 && !m_rvalid));
endmodule

// File: rtl/devbus_hub.sv
module devbus_hub
    import devbus_pkg::*;
#(
    parameter int unsigned ADDR_W  = ADDR_W_DEF,
    parameter int unsigned DATA_W  = DATA_W_DEF,
    parameter int unsigned SEL_W   = SEL_W_DEF,
    parameter int unsigned NUM_SLV = 12,
    localparam int unsigned PORT_W = ADDR_W - SEL_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         m_addr,
    input  logic [DATA_W-1:0]         m_wdata,
    input  logic                      m_wr,
    input  logic                      m_rd,
    output logic [DATA_W-1:0]         m_rdata,
    output logic                      m_rvalid,
    output logic                      m_ready,
    output logic                      m_avail,
    output logic                      m_stall,
    output logic [PORT_W-1:0]         s_port,
    output logic [DATA_W-1:0]         s_wdata,
    output logic [NUM_SLV-1:0]        s_wr,
    output logic [NUM_SLV-1:0]        s_rd,
    input  logic [NUM_SLV*DATA_W-1:0] s_rdata,
    input  logic [NUM_SLV-1:0]        s_ready,
    input  logic [NUM_SLV-1:0]        s_avail
);
    logic [NUM_SLV-1:0] sel_oh;
    rd_res_e            rd_res;

    assign s_wdata = m_wdata;

    devbus_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .NUM_SLV(NUM_SLV)) u_dec (
        .addr   (m_addr),
        .sel_oh (sel_oh),
        .port   (s_port)
    );

    devbus_status #(.NUM_SLV(NUM_SLV)) u_stat (
        .sel_oh  (sel_oh),
        .s_ready (s_ready),
        .s_avail (s_avail),
        .m_wr    (m_wr),
        .m_rd    (m_rd),
        .ready   (m_ready),
        .avail   (m_avail),
        .stall   (m_stall),
        .wr_oh   (s_wr),
        .rd_oh   (s_rd),
        .rd_res  (rd_res)
    );

    devbus_retmux #(.DATA_W(DATA_W), .NUM_SLV(NUM_SLV)) u_ret (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_oh   (sel_oh),
        .s_rdata  (s_rdata),
        .rd_res   (rd_res),
        .m_rdata  (m_rdata),
        .m_rvalid (m_rvalid)
    );

    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_wr) && $onehot0(s_rd));
    a_r6_write_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_wr & ~s_ready) == '0) && (m_wr || s_wr == '0));
    a_r7_read_needs_avail: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_rd & ~s_avail) == '0) && (m_rd || s_rd == '0));
    a_r8_stall_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wr && !m_ready) |-> (m_stall && s_wr == '0));
    a_r9_taken_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rd && m_avail) |=> m_rvalid);
    a_r5_empty_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (m_addr[ADDR_W-1 -: SEL_W] >= SEL_W'(NUM_SLV)) |->
            (!m_ready && !m_avail && s_wr == '0 && s_rd == '0));
endmodule

// File: tb/devbus_hub_tb_top.sv
module devbus_hub_tb_top;
    localparam int NS = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   m_addr = '0;
    logic [31:0]   m_wdata = '0;
    logic          m_wr = 1'b0;
    logic          m_rd = 1'b0;
    logic [31:0]   m_rdata;
    logic          m_rvalid, m_ready, m_avail, m_stall;
    logic [27:0]   s_port;
    logic [31:0]   s_wdata;
    logic [NS-1:0] s_wr, s_rd;
    logic [NS*DW-1:0] s_rdata;
    logic [NS-1:0] s_ready = '0;
    logic [NS-1:0] s_avail = '0;

    logic [31:0] stub_reg [NS];
    logic [31:0] mdl_reg  [NS];
    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    devbus_hub #(.NUM_SLV(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_wr(m_wr), .m_rd(m_rd), .m_rdata(m_rdata), .m_rvalid(m_rvalid),
        .m_ready(m_ready), .m_avail(m_avail), .m_stall(m_stall),
        .s_port(s_port), .s_wdata(s_wdata), .s_wr(s_wr), .s_rd(s_rd),
        .s_rdata(s_rdata), .s_ready(s_ready), .s_avail(s_avail)
    );

    // register stubs standing in for peripherals
    always_comb begin
        for (int i = 0; i < NS; i++)
            s_rdata[i*DW +: DW] = stub_reg[i] ^ {4'(i), s_port};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) stub_reg[i] <= 32'h0101_0101 * i;
        end else begin
            for (int i = 0; i < NS; i++)
                if (s_wr[i]) stub_reg[i] <= s_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic [31:0] a, input logic [31:0] wd, input logic w, input logic r,
                       input logic [NS-1:0] rdy, input logic [NS-1:0] av);
        int slot;
        bit mapped, er, ea;
        logic [NS-1:0] ewr, erd;
        logic [31:0] edata;
        logic evalid;
        m_addr = a; m_wdata = wd; m_wr = w; m_rd = r; s_ready = rdy; s_avail = av;
        #2;
        slot   = int'(a[31:28]);
        mapped = slot < NS;
        er     = mapped && rdy[slot];
        ea     = mapped && av[slot];
        ewr    = (w && er) ? NS'(1) << slot : '0;
        erd    = (r && ea) ? NS'(1) << slot : '0;
        chk(m_ready == er && m_avail == ea, mapped ? "R4 status flags" : "R5 empty slot flags",
            {m_ready, m_avail}, {er, ea});
        chk(s_wr == ewr, "R6 R2 R11 write strobe", s_wr, ewr);
        chk(s_rd == erd, "R7 R2 R11 read strobe", s_rd, erd);
        chk(m_stall == ((w && !er) || (r && !ea)), "R8 stall", m_stall, (w && !er) || (r && !ea));
        chk(s_port == a[27:0] && s_wdata == wd, "R3 broadcast", {s_port, s_wdata}, {a[27:0], wd});
        evalid = r && ea;
        if (!r) edata = m_rdata;
        else if (ea) edata = mdl_reg[slot] ^ {a[31:28], a[27:0]};
        else edata = '0;
        @(posedge clk);
        if (w && er) mdl_reg[slot] = wd;
        @(negedge clk);
        chk(m_rdata == edata && m_rvalid == evalid,
            evalid ? "R9 R11 read return" : (mapped ? "R10 read return" : "R5 empty read return"),
            {m_rdata, m_rvalid}, {edata, evalid});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) mdl_reg[i] = 32'h0101_0101 * i;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(m_rdata == '0 && !m_rvalid, "R1 reset state", {m_rdata, m_rvalid}, '0);
        // directed: accepted read on slot 0
        cyc(32'h0000_0003, 32'h0, 1'b0, 1'b1, '1, '1);
        // idle holds data (R10)
        cyc(32'h0000_0003, 32'h0, 1'b0, 1'b0, '1, '1);
        // write then read back on last populated slot (R6, R9)
        cyc(32'hB000_0010, 32'hCAFE_F00D, 1'b1, 1'b0, '1, '0);
        cyc(32'hB000_0010, 32'h0, 1'b0, 1'b1, '0, '1);
        // blocked write and blocked read (R8, R10)
        cyc(32'h5000_0001, 32'h1234_5678, 1'b1, 1'b1, '0, '0);
        // same-slot write and read together: read sees old word (R11)
        cyc(32'h2FFF_FFFF, 32'hA5A5_5A5A, 1'b1, 1'b1, '1, '1);
        cyc(32'h2FFF_FFFF, 32'h0, 1'b0, 1'b1, '1, '1);
        // write taken, read blocked, same cycle (R11)
        cyc(32'h4000_0002, 32'h0BAD_BEEF, 1'b1, 1'b1, '1, '0);
        // read taken, write blocked, same cycle (R11)
        cyc(32'h4000_0002, 32'h7777_7777, 1'b1, 1'b1, '0, '1);
        // empty slots 12 and 15 (R5)
        cyc(32'hC000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, '1, '1);
        cyc(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, '1, '1);
        cyc(32'hF000_0000, 32'h0, 1'b0, 1'b0, '1, '1);
        // pseudo-random traffic
        for (int k = 0; k < 3000; k++) begin
            cyc({4'($urandom_range(0, 15)), 28'($urandom)}, $urandom,
                1'($urandom), 1'($urandom), NS'($urandom), NS'($urandom));
        end
        // reset mid-run returns to reset state (R1)
        rst_n = 1'b0;
        @(negedge clk);
        chk(m_rdata == '0 && !m_rvalid, "R1 reset state again", {m_rdata, m_rvalid}, '0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule